// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder Core

This block recovers the information bits of a rate-1/2, constraint-length-7 convolutional code from soft-quantized received symbols. Each valid cycle carries one pair of 3-bit soft symbols, one per code bit, and a two-bit inhibit mask. An inhibited symbol, such as a punctured position that an upstream stage filled with a dummy value, contributes nothing to the branch metrics. A branch metric unit feeds 64 parallel add-compare-select units. Each unit owns one 10-bit path metric. The survivors are kept by register exchange.

The decoded bit does not come from a traceback. It is a majority vote over the oldest bit of all 64 survivor registers, so the output stage is a single population count. The block emits one decoded bit for every valid input once its 36-deep survivor window has filled. Bits come out in source order, and the output lags the input by a fixed 35 valid inputs.

Top module: `soft_viterbi_dec`

## Requirements
- R1: While rst_ni is low, valid_o and bit_o are 0. Reset clears every path metric and every survivor bit to zero.
- R2: The code register is {u(t), u(t-1), ..., u(t-6)}, with the newest bit as bit 6. Code bit c0 is the parity of that register masked by 171 octal, and c1 is the parity masked by 133 octal. soft0_i carries c0 and soft1_i carries c1. A noise-free encoded stream that starts from the all-zero encoder state decodes without error.
- R3: A soft symbol is a 3-bit unsigned value, where 0 is a confident 0 and 7 is a confident 1. A branch scores y where the expected bit is 1, and 7-y where it is 0. Each state keeps the predecessor with the larger sum of old metric plus branch score. Sparse full-strength symbol errors together with softened symbols are corrected.
- R4: inhibit_i[0] gates soft0_i and inhibit_i[1] gates soft1_i. An inhibited symbol adds 0 to every branch, whatever its value.
- R5: The predecessors of state n are 2n mod 64 and 2n mod 64 + 1. On equal candidate metrics, the lower-index predecessor wins. As a result, fully inhibited input after reset decodes to all zeros.
- R6: The decoded bit is 1 only when more than 32 of the 64 survivors hold 1 in their oldest position. A 32/32 split gives 0.
- R7: valid_o pulses one cycle after every valid input from the 36th valid input after reset onward. The k-th output bit decodes the k-th input bit.
- R8: A cycle with valid_i low leaves the metrics and survivors unchanged, drives valid_o low and holds bit_o, whatever the symbol and inhibit inputs carry.
- R9: Path metrics are 10 bits wide. When any metric has bit 9 set, 256 is subtracted from all 64 metrics in the same update, so no metric ever reaches 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The symbol pair on this cycle is live |
| soft0_i | input | 3 | Soft value for code bit c0 (171 octal) |
| soft1_i | input | 3 | Soft value for code bit c1 (133 octal) |
| inhibit_i | input | 2 | Per-symbol metric gate; bit 0 for soft0_i, bit 1 for soft1_i |
| valid_o | output | 1 | bit_o carries a new decoded bit |
| bit_o | output | 1 | Decoded information bit |

## Verification
The bench drives fully inhibited data right after reset. A design that broke compare ties toward the higher predecessor, or that did not clear its survivors, would emit ones here instead of zeros. Inhibited positions are filled with inverted confident values, so a design that ignored the gate would pick up a burst of errors. Idle cycles carrying garbage are mixed into the stream: a design that updated on them would lose both the bit count and the alignment of its output. A 3000-bit stream drives the metrics through many normalisation steps, where a wrong offset or threshold shows up as wrapped metrics and decoding errors. A count of the inputs issued before the first valid_o catches any off-by-one in the depth of the survivor window.

// File: rtl/svd_pkg.sv
package svd_pkg;

  typedef struct packed {
    logic valid;
    logic data;
  } dec_out_t;

  // predecessor of state s (ns states) whose dropped oldest bit is b
  function automatic int pred_state(input int s, input int ns, input int b);
    return ((2 * s) % ns) + b;
  endfunction

endpackage

// File: rtl/svd_bmu.sv
module svd_bmu #(
  parameter int SYM_W = 3,
  parameter int BM_W  = SYM_W + 1
) (
  input  logic [SYM_W-1:0]       sym0_i,
  input  logic [SYM_W-1:0]       sym1_i,
  input  logic [1:0]             inh_i,
  output logic [3:0][BM_W-1:0]   bm_o    // index {c0, c1}
);
  localparam logic [SYM_W-1:0] SMAX = '1;

  logic [3:0][SYM_W-1:0] t0, t1;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      t0[c] = inh_i[0] ? '0 : (c[1] ? sym0_i : SMAX - sym0_i);
      t1[c] = inh_i[1] ? '0 : (c[0] ? sym1_i : SMAX - sym1_i);
      bm_o[c] = BM_W'(t0[c]) + BM_W'(t1[c]);
    end
  end
endmodule

// File: rtl/svd_acs.sv
module svd_acs #(
  parameter int K     = 7,
  parameter int PM_W  = 10,
  parameter int BM_W  = 4,
  parameter int STATE = 0,
  parameter logic [K-1:0] G0 = 'o171,
  parameter logic [K-1:0] G1 = 'o133
) (
  input  logic [PM_W-1:0]      pm_a_i,  // lower-index predecessor
  input  logic [PM_W-1:0]      pm_b_i,
  input  logic [3:0][BM_W-1:0] bm_i,
  input  logic                 norm_i,
  output logic [PM_W-1:0]      pm_o,
  output logic                 sel_o
);
  localparam int NS        = 1 << (K - 1);
  localparam int SUM_W     = PM_W + 1;
  localparam int NORM_STEP = 1 << (PM_W - 2);
  localparam int IN_BIT    = (STATE >> (K - 2)) & 1;
  localparam int PA        = svd_pkg::pred_state(STATE, NS, 0);
  localparam int RA        = (IN_BIT << (K - 1)) | PA;
  localparam int RB        = RA + 1;
  localparam logic [K-1:0] RAV = RA[K-1:0];
  localparam logic [K-1:0] RBV = RB[K-1:0];
  localparam int CODE_A    = {30'd0, ^(RAV & G0), ^(RAV & G1)};
  localparam int CODE_B    = {30'd0, ^(RBV & G0), ^(RBV & G1)};

  logic [SUM_W-1:0] cand_a, cand_b, best;

  always_comb begin
    cand_a = {1'b0, pm_a_i} + SUM_W'(bm_i[CODE_A]);
    cand_b = {1'b0, pm_b_i} + SUM_W'(bm_i[CODE_B]);
    sel_o  = cand_b > cand_a;   // tie keeps lower index
    best   = sel_o ? cand_b : cand_a;
    pm_o   = PM_W'(best - (norm_i ? SUM_W'(NORM_STEP) : '0));
  end
endmodule

// File: rtl/svd_path_bank.sv
module svd_path_bank #(
  parameter int NS       = 64,
  parameter int PATH_LEN = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [NS-1:0] sel_i,
  output logic          dec_o
);
  localparam int CW = $clog2(NS + 1);
  localparam int SW = PATH_LEN - 1;   // output register is the last stage

  logic [NS-1:0][SW-1:0] path_q, path_d;
  logic [NS-1:0]         oldest;
  logic [CW-1:0]         ones;

  for (genvar s = 0; s < NS; s++) begin : g_path
    localparam int PA = svd_pkg::pred_state(s, NS, 0);
    localparam int PB = svd_pkg::pred_state(s, NS, 1);
    localparam logic DBIT = (s >= NS / 2);
    logic [SW-1:0] src;
    assign src         = sel_i[s] ? path_q[PB] : path_q[PA];
    assign path_d[s]   = {src[SW-2:0], DBIT};
    assign oldest[s]   = src[SW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      path_q <= '0;
    else if (valid_i) path_q <= path_d;
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < NS; i++) ones = ones + CW'(oldest[i]);
    dec_o = ones > CW'(NS / 2);
  end
endmodule

// File: rtl/soft_viterbi_dec.sv
module soft_viterbi_dec
  import svd_pkg::*;
#(
  parameter int SYM_W    = 3,
  parameter int K        = 7,
  parameter int PM_W     = 10,
  parameter int PATH_LEN = 36,
  parameter logic [K-1:0] G0 = 'o171,
  parameter logic [K-1:0] G1 = 'o133
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SYM_W-1:0] soft0_i,
  input  logic [SYM_W-1:0] soft1_i,
  input  logic [1:0]       inhibit_i,
  output logic             valid_o,
  output logic             bit_o
);
  localparam int NS    = 1 << (K - 1);
  localparam int BM_W  = SYM_W + 1;
  localparam int CNT_W = $clog2(PATH_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PATH_LEN - 1);

  logic [3:0][BM_W-1:0]  bm;
  logic [NS-1:0][PM_W-1:0] pm_q, pm_d;
  logic [NS-1:0]         sel;
  logic                  norm, dec;
  logic [CNT_W-1:0]      fill_q;
  dec_out_t              out_q;

  svd_bmu #(.SYM_W(SYM_W), .BM_W(BM_W)) u_bmu (
    .sym0_i(soft0_i), .sym1_i(soft1_i), .inh_i(inhibit_i), .bm_o(bm)
  );

  always_comb begin
    norm = 1'b0;
    for (int i = 0; i < NS; i++) norm = norm | pm_q[i][PM_W-1];
  end

  for (genvar s = 0; s < NS; s++) begin : g_acs
    localparam int PA = pred_state(s, NS, 0);
    localparam int PB = pred_state(s, NS, 1);
    svd_acs #(
      .K(K), .PM_W(PM_W), .BM_W(BM_W), .STATE(s), .G0(G0), .G1(G1)
    ) u_acs (
      .pm_a_i(pm_q[PA]), .pm_b_i(pm_q[PB]), .bm_i(bm),
      .norm_i(norm), .pm_o(pm_d[s]), .sel_o(sel[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pm_q <= '0;
    else if (valid_i) pm_q <= pm_d;
  end

  svd_path_bank #(.NS(NS), .PATH_LEN(PATH_LEN)) u_paths (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sel_i(sel), .dec_o(dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      out_q  <= '0;
    end else begin
      out_q.valid <= valid_i && (fill_q == LAST);
      if (valid_i && fill_q != LAST) fill_q <= fill_q + 1'b1;
      if (valid_i && fill_q == LAST) out_q.data <= dec;
    end
  end

  assign valid_o = out_q.valid;
  assign bit_o   = out_q.data;
endmodule

// File: rtl/svd_chk.sv
module svd_chk #(
  parameter int NS   = 64,
  parameter int PM_W = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  valid_o,
  input logic                  bit_o,
  input logic [NS-1:0][PM_W-1:0] pm_i
);
  localparam logic [PM_W-1:0] CEIL = PM_W'(3 << (PM_W - 2));

  logic too_high;
  always_comb begin
    too_high = 1'b0;
    for (int i = 0; i < NS; i++) too_high = too_high | (pm_i[i] >= CEIL);
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !bit_o);

  a_r7_output_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  a_r8_idle_metrics: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pm_i));

  a_r8_idle_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(bit_o) && !valid_o);

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni) !too_high);
endmodule

bind soft_viterbi_dec svd_chk #(.NS(NS), .PM_W(PM_W)) i_svd_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .valid_o(valid_o), .bit_o(bit_o), .pm_i(pm_q)
);

// File: tb/test_soft_viterbi_dec.sv
module test_soft_viterbi_dec;
  localparam int CLK_PERIOD = 10;
  localparam int FLUSH = 35;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [2:0] soft0_i = '0, soft1_i = '0;
  logic [1:0] inhibit_i = '0;
  logic valid_o, bit_o;

  int checks = 0, errors = 0;
  logic [5:0] enc_st;
  bit srcq[$];
  bit outq[$];

  soft_viterbi_dec i_soft_viterbi_dec (
    .clk_i, .rst_ni, .valid_i, .soft0_i, .soft1_i, .inhibit_i, .valid_o, .bit_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  always @(negedge clk_i) if (rst_ni && valid_o) outq.push_back(bit_o);

  function automatic void check(input string req, input bit ok, input string what,
                                input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // returns {c0, c1}; masks 171 and 133 octal on {u(t), state}
  function automatic logic [1:0] encode(input logic b);
    logic [6:0] r;
    r = {b, enc_st};
    enc_st = r[6:1];
    return {^(r & 7'b1111001), ^(r & 7'b1011011)};
  endfunction

  task automatic drive(input logic v, input logic [2:0] a, input logic [2:0] b,
                       input logic [1:0] inh);
    @(negedge clk_i);
    valid_i = v; soft0_i = a; soft1_i = b; inhibit_i = inh;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0; soft0_i = '0; soft1_i = '0; inhibit_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    enc_st = '0;
    outq.delete();
    srcq.delete();
  endtask

  task automatic finish_and_compare(input string req, input int n);
    int mism = 0;
    repeat (4) drive(1'b0, 3'd0, 3'd0, 2'b00);
    check(req, outq.size() == n, "output count", outq.size(), n);
    for (int i = 0; i < n && i < outq.size(); i++) if (outq[i] != srcq[i]) mism++;
    check(req, mism == 0, "bit mismatches", mism, 0);
  endtask

  // mode: 0 random, 1 zeros, 2 ones, 3 light noise, 4 inhibit, 5 idle gaps
  task automatic run_stream(input string req, input int n, input int mode);
    logic b;
    logic [1:0] c, inh;
    logic [2:0] y0, y1;
    do_reset();
    for (int i = 0; i < n + FLUSH; i++) begin
      if (i < n) begin
        b = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : 1'($urandom_range(0, 1));
        srcq.push_back(b);
      end else b = 1'b0;
      c = encode(b);
      y0 = c[1] ? 3'd7 : 3'd0;
      y1 = c[0] ? 3'd7 : 3'd0;
      inh = 2'b00;
      if (mode == 3) begin
        if (((2 * i) % 23) == 7) y0 = c[1] ? 3'd1 : 3'd6;
        else if ($urandom_range(0, 3) == 0) y0 = c[1] ? 3'd5 : 3'd2;
        if (((2 * i + 1) % 23) == 7) y1 = c[0] ? 3'd1 : 3'd6;
        else if ($urandom_range(0, 3) == 0) y1 = c[0] ? 3'd5 : 3'd2;
      end
      if (mode == 4) begin
        if (i % 4 == 2) begin inh[1] = 1'b1; y1 = c[0] ? 3'd0 : 3'd7; end
        if (i % 7 == 5) begin inh[0] = 1'b1; y0 = c[1] ? 3'd0 : 3'd7; end
      end
      if (mode == 5)
        while ($urandom_range(0, 2) == 0)
          drive(1'b0, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                2'($urandom_range(0, 3)));
      drive(1'b1, y0, y1, inh);
    end
    finish_and_compare(req, n);
  endtask

  // R1 reset state, R7 first output after 36 inputs
  task automatic test_latency();
    int first = -1;
    logic [1:0] c;
    do_reset();
    @(negedge clk_i);
    check("R1", valid_o == 1'b0 && bit_o == 1'b0, "outputs after reset",
          {valid_o, bit_o}, 0);
    for (int i = 0; i < 40; i++) begin
      if (i > 0) @(negedge clk_i);
      if (first < 0 && valid_o) first = i;
      c = encode(1'($urandom_range(0, 1)));
      valid_i = 1'b1; soft0_i = c[1] ? 3'd7 : 3'd0; soft1_i = c[0] ? 3'd7 : 3'd0;
      inhibit_i = 2'b00;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R7", first == 36, "inputs before first valid_o", first, 36);
  endtask

  // R5 tie rule (and R4, R1): fully inhibited input decodes to zeros
  task automatic test_all_inhibit();
    int ones = 0;
    do_reset();
    for (int i = 0; i < 60; i++)
      drive(1'b1, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 2'b11);
    repeat (4) drive(1'b0, 3'd0, 3'd0, 2'b00);
    check("R7", outq.size() == 25, "output count", outq.size(), 25);
    foreach (outq[i]) if (outq[i]) ones++;
    check("R5", ones == 0, "ones under full inhibit", ones, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    enc_st = '0;
    test_latency();
    test_all_inhibit();
    run_stream("R2", 200, 0);
    run_stream("R2", 80, 1);
    run_stream("R2", 80, 2);
    run_stream("R3", 400, 3);
    run_stream("R4", 300, 4);
    run_stream("R8", 300, 5);
    run_stream("R9", 3000, 0);   // also R6 majority decision over long run
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule